// File: doc/BRIEF.md
# Masked-Write PHY Configuration Bridge

This block sits between a simple host register port and the narrow configuration bus of a PHY. The host sees three 32-bit words: a configuration control word, a lane power word and a read-only status word. The two writable words use a per-bit write mask. The upper 16 bits of every written word choose which of the lower 16 bits take the new value. Software can change one field without a read-modify-write, and several agents can share one word without losing each other's updates.

A configuration write to the PHY takes three host writes. The first places a 6-bit address and a 4-bit data value in the control word. The second sets the strobe bit. The third clears the strobe bit. The bridge turns the rising edge of the strobe bit into a single-cycle write pulse on the PHY bus.

For reads, the host writes a 10-bit read address. The bridge drives it to the PHY and returns the PHY's answer through the status word. The status word also carries the PLL lock and PLL output flags. The lane power word drives one idle control per lane.

Top module: `phycfg_bridge`

## Requirements
- R1: After reset every stored bit is zero: `host_rdata`, `phy_cfg_addr`, `phy_cfg_data`, `phy_rd_addr` and `lane_idle` read zero, and `phy_cfg_wr` is low.
- R2: A host write to the control word (`host_sel`=0) or the lane word (`host_sel`=1) updates lower bit x only when bit x+16 of `host_wdata` is 1; every other lower bit keeps its value.
- R3: Bits 31:16 of `host_rdata` are always zero, whatever has been written.
- R4: `phy_cfg_addr` equals control bits 6:1 and `phy_cfg_data` equals control bits 10:7, from the cycle after the write that set them.
- R5: `phy_cfg_wr` is high for exactly one cycle, in the cycle after a write that changes control bit 0 from 0 to 1. Writing bit 0 to 1 again while it is already 1 gives no further pulse.
- R6: A write that clears control bit 0, or that leaves it at 0, gives no pulse on `phy_cfg_wr`.
- R7: `phy_rd_addr` equals control bits 10:1. This is the 10-bit read address field starting at bit 1.
- R8: The status word (`host_sel`=2) reads `phy_rd_data` in bits 8:0, `pll_locked` in bit 9 and `pll_out_on` in bit 10, with all other bits zero. The inputs are sampled one clock before the read is taken.
- R9: `lane_idle[i]` equals lane word bit 3+i, so lane A is bit 3 and lane D is bit 6. A 1 puts the lane into idle.
- R10: Host writes with `host_sel`=2 or 3 change no stored bit and no output.
- R11: `host_rdata` takes the selected word at the clock edge where `host_re` is high, and holds its value otherwise. Selector 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write request |
| host_re | input | 1 | Host read request |
| host_sel | input | 2 | Word select: 0 control, 1 lane, 2 status, 3 unused |
| host_wdata | input | 32 | Write data; bits 31:16 are the per-bit write mask |
| host_rdata | output | 32 | Read data, registered |
| phy_cfg_addr | output | 6 | PHY configuration address |
| phy_cfg_data | output | 4 | PHY configuration write data |
| phy_cfg_wr | output | 1 | One-cycle PHY configuration write pulse |
| phy_rd_addr | output | 10 | PHY read address |
| phy_rd_data | input | 9 | PHY read result |
| pll_locked | input | 1 | PLL lock flag from the PHY |
| pll_out_on | input | 1 | PLL output flag from the PHY |
| lane_idle | output | 4 | Per-lane idle controls |

## Verification
The masked write is exercised in three ways. Fully random data with fully random masks separates a correct per-bit merge from a whole-word write or an inverted mask. Writes with an all-zero mask show that unmasked bits really hold. Single-field masks, as a driver uses them, show that the fields do not overlap. The strobe is driven through a 0-to-1 step, a repeated 1, a clear and a stay-at-0, which tells edge detection apart from level following. Status reads with changing PLL flags and read data check that each status bit lands in the right position.

// File: rtl/phycfg_pkg.sv
package phycfg_pkg;

    localparam int HALF_W     = 16;
    localparam int WORD_W     = 2 * HALF_W;

    // control word field layout
    localparam int STROBE_BIT = 0;
    localparam int ADDR_LSB   = 1;
    localparam int ADDR_W     = 6;
    localparam int DATA_LSB   = ADDR_LSB + ADDR_W;
    localparam int DATA_W     = 4;
    localparam int RADDR_W    = 10;

    // status word layout
    localparam int RDATA_W    = 9;
    localparam int LOCK_BIT   = 9;
    localparam int PLLOUT_BIT = 10;

    // lane word layout
    localparam int LANE_LSB   = 3;

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_LANE = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } word_sel_e;

    function automatic logic [HALF_W-1:0] merge_masked(
        input logic [HALF_W-1:0] old_val,
        input logic [WORD_W-1:0] wr_word
    );
        logic [HALF_W-1:0] mask;
        mask = wr_word[WORD_W-1:HALF_W];
        return (old_val & ~mask) | (wr_word[HALF_W-1:0] & mask);
    endfunction

endpackage

// File: rtl/phycfg_mask_reg.sv
module phycfg_mask_reg
    import phycfg_pkg::*;
#(
    parameter int W = HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2*W-1:0]    wr_word,
    output logic [W-1:0]      q
);

    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (wr_en) begin
            for (int i = 0; i < W; i++) begin
                if (wr_word[W+i]) val_d[i] = wr_word[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign q = val_q;

    // R2: bits without a mask bit keep their value
    p_unmasked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (((val_q ^ $past(val_q)) & ~$past(wr_word[2*W-1:W])) == '0));

    // R10: nothing changes without a write
    p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(val_q));

endmodule

// File: rtl/phycfg_strobe.sv
module phycfg_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic pulse
);

    logic prev_d, prev_q;

    always_comb prev_d = level;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign pulse = level & ~prev_q;

    // R5: a pulse only follows a 0-to-1 step of the level
    p_pulse_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (level && !$past(level)));

    // R5: a pulse never lasts two cycles
    p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

endmodule

// File: rtl/phycfg_bridge.sv
module phycfg_bridge
    import phycfg_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_we,
    input  logic                 host_re,
    input  logic [1:0]           host_sel,
    input  logic [WORD_W-1:0]    host_wdata,
    output logic [WORD_W-1:0]    host_rdata,
    output logic [ADDR_W-1:0]    phy_cfg_addr,
    output logic [DATA_W-1:0]    phy_cfg_data,
    output logic                 phy_cfg_wr,
    output logic [RADDR_W-1:0]   phy_rd_addr,
    input  logic [RDATA_W-1:0]   phy_rd_data,
    input  logic                 pll_locked,
    input  logic                 pll_out_on,
    output logic [NUM_LANES-1:0] lane_idle
);

    localparam int LANE_MSB = LANE_LSB + NUM_LANES - 1;

    typedef struct packed {
        logic [HALF_W-1:0] stat;
        logic [WORD_W-1:0] rdata;
    } rd_state_t;

    rd_state_t rs_d, rs_q;

    logic [HALF_W-1:0] cfg_word;
    logic [HALF_W-1:0] lane_word;
    logic              cfg_we, lane_we;

    assign cfg_we  = host_we && (word_sel_e'(host_sel) == SEL_CFG);
    assign lane_we = host_we && (word_sel_e'(host_sel) == SEL_LANE);

    phycfg_mask_reg #(.W(HALF_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_word (host_wdata),
        .q       (cfg_word)
    );

    phycfg_mask_reg #(.W(HALF_W)) u_lane (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (lane_we),
        .wr_word (host_wdata),
        .q       (lane_word)
    );

    phycfg_strobe u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .level (cfg_word[STROBE_BIT]),
        .pulse (phy_cfg_wr)
    );

    always_comb begin
        rs_d = rs_q;
        rs_d.stat = '0;
        rs_d.stat[RDATA_W-1:0] = phy_rd_data;
        rs_d.stat[LOCK_BIT]    = pll_locked;
        rs_d.stat[PLLOUT_BIT]  = pll_out_on;
        if (host_re) begin
            unique case (word_sel_e'(host_sel))
                SEL_CFG:  rs_d.rdata = {{HALF_W{1'b0}}, cfg_word};
                SEL_LANE: rs_d.rdata = {{HALF_W{1'b0}}, lane_word};
                SEL_STAT: rs_d.rdata = {{HALF_W{1'b0}}, rs_q.stat};
                default:  rs_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign host_rdata   = rs_q.rdata;
    assign phy_cfg_addr = cfg_word[ADDR_LSB +: ADDR_W];
    assign phy_cfg_data = cfg_word[DATA_LSB +: DATA_W];
    assign phy_rd_addr  = cfg_word[ADDR_LSB +: RADDR_W];
    assign lane_idle    = lane_word[LANE_MSB:LANE_LSB];

    // R3: upper half of read data is always zero
    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[WORD_W-1:HALF_W] == '0);

    // R11: read data holds when no read is requested
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !host_re |=> $stable(host_rdata));

    // R9/R10: lane controls move only on a write
    p_lane_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !host_we |=> $stable(lane_idle));

    // R6: without a write no new configuration pulse may start
    p_no_pulse_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !host_we |=> !phy_cfg_wr);

endmodule

// File: tb/sim_phycfg_bridge.sv
module sim_phycfg_bridge;
    import phycfg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_we, host_re;
    logic [1:0]  host_sel;
    logic [31:0] host_wdata;
    logic [31:0] host_rdata;
    logic [5:0]  phy_cfg_addr;
    logic [3:0]  phy_cfg_data;
    logic        phy_cfg_wr;
    logic [9:0]  phy_rd_addr;
    logic [8:0]  phy_rd_data;
    logic        pll_locked, pll_out_on;
    logic [3:0]  lane_idle;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] m_cfg, m_lane;

    always #10 clk = ~clk;

    phycfg_bridge #(.NUM_LANES(4)) u0 (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .phy_cfg_addr(phy_cfg_addr), .phy_cfg_data(phy_cfg_data),
        .phy_cfg_wr(phy_cfg_wr), .phy_rd_addr(phy_rd_addr),
        .phy_rd_data(phy_rd_data), .pll_locked(pll_locked),
        .pll_out_on(pll_out_on), .lane_idle(lane_idle)
    );

    function automatic logic [15:0] exp_merge(input logic [15:0] o, input logic [31:0] w);
        return (o & ~w[31:16]) | (w[15:0] & w[31:16]);
    endfunction

    function automatic logic [31:0] exp_status(input logic [8:0] d, input logic lk, input logic po);
        return {21'b0, po, lk, d};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_outputs(input string req);
        chk({req, " addr R4"},  {26'b0, phy_cfg_addr}, {26'b0, m_cfg[6:1]});
        chk({req, " data R4"},  {28'b0, phy_cfg_data}, {28'b0, m_cfg[10:7]});
        chk({req, " raddr R7"}, {22'b0, phy_rd_addr},  {22'b0, m_cfg[10:1]});
        chk({req, " lane R9"},  {28'b0, lane_idle},    {28'b0, m_lane[6:3]});
    endtask

    // one host write; returns at the negedge after the capturing edge
    task automatic hwrite(input logic [1:0] sel, input logic [31:0] w, input string req);
        logic exp_pulse;
        exp_pulse = 1'b0;
        host_we = 1'b1; host_sel = sel; host_wdata = w;
        @(posedge clk);
        @(negedge clk);
        host_we = 1'b0;
        if (sel == 2'd0) begin
            exp_pulse = exp_merge(m_cfg, w)[0] & ~m_cfg[0];
            m_cfg = exp_merge(m_cfg, w);
        end else if (sel == 2'd1) begin
            m_lane = exp_merge(m_lane, w);
        end
        chk({req, " strobe R5/R6"}, {31'b0, phy_cfg_wr}, {31'b0, exp_pulse});
        chk_outputs(req);
    endtask

    task automatic hread(input logic [1:0] sel, output logic [31:0] d);
        host_re = 1'b1; host_sel = sel;
        @(posedge clk);
        @(negedge clk);
        host_re = 1'b0;
        d = host_rdata;
    endtask

    task automatic chk_readback(input string req);
        logic [31:0] d;
        hread(2'd0, d);
        chk({req, " cfg readback R2/R3"}, d, {16'b0, m_cfg});
        hread(2'd1, d);
        chk({req, " lane readback R2/R3"}, d, {16'b0, m_lane});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] hold;
        void'($urandom(32'd1234));
        rst_n = 1'b0; host_we = 1'b0; host_re = 1'b0; host_sel = 2'd0;
        host_wdata = '0; phy_rd_data = '0; pll_locked = 1'b0; pll_out_on = 1'b0;
        m_cfg = '0; m_lane = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 rdata", host_rdata, 32'h0);
        chk("R1 strobe", {31'b0, phy_cfg_wr}, 32'h0);
        chk_outputs("R1");

        // R4 / R5: three-step configuration write, field-only masks
        hwrite(2'd0, {16'h07FE, 5'b0, 4'hA, 6'h30, 1'b0}, "R4 set fields");
        hwrite(2'd0, 32'h0001_0001, "R5 strobe rise");
        @(negedge clk);
        chk("R5 pulse ends", {31'b0, phy_cfg_wr}, 32'h0);
        hwrite(2'd0, 32'h0001_0001, "R5 strobe repeat");
        hwrite(2'd0, 32'h0001_0000, "R6 strobe clear");
        hwrite(2'd0, 32'h0001_0000, "R6 strobe stays low");
        // a mask without bit 0 leaves the strobe alone
        hwrite(2'd0, 32'h0000_FFFF, "R2 zero mask");
        chk_readback("R2 zero mask");

        // R9: lane idle bits, one at a time
        for (int i = 0; i < 4; i++) begin
            hwrite(2'd1, 32'h1 << (16 + 3 + i) | 32'h1 << (3 + i), "R9 lane set");
        end
        hwrite(2'd1, 32'h0010_0000, "R9 lane B clear");

        // R10: writes to status and unused words change nothing
        hwrite(2'd2, 32'hFFFF_FFFF, "R10 status write");
        hwrite(2'd3, 32'hFFFF_FFFF, "R10 unused write");
        chk_readback("R10");
        hread(2'd3, d);
        chk("R11 unused reads zero", d, 32'h0);

        // R8: status word with varied inputs
        for (int i = 0; i < 8; i++) begin
            phy_rd_data = 9'($urandom);
            pll_locked  = i[0];
            pll_out_on  = i[1];
            @(negedge clk);
            hread(2'd2, d);
            chk("R8 status", d, exp_status(phy_rd_data, pll_locked, pll_out_on));
        end

        // R11: rdata holds without host_re
        hold = host_rdata;
        phy_rd_data = ~phy_rd_data;
        hwrite(2'd0, 32'hFFFF_FFFF, "R11 write no read");
        repeat (2) @(negedge clk);
        chk("R11 hold", host_rdata, hold);

        // random mix of writes and reads
        for (int i = 0; i < 300; i++) begin
            logic [31:0] w;
            logic [1:0]  s;
            w = $urandom;
            s = 2'($urandom);
            if ((i % 3) == 0) w[16] = 1'b1;
            hwrite(s, w, "R2 random");
            if ((i % 10) == 0) chk_readback("R3 random");
        end

        // R1: reset clears everything again
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_cfg = '0; m_lane = '0;
        chk("R1 re-reset rdata", host_rdata, 32'h0);
        chk_outputs("R1 re-reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule